// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single-register load or store and, in the same step, the value that the base register should take afterwards. It takes the base register contents and one offset. The offset is either a 12-bit unsigned immediate or a second register. The register can pass through a shifter with an immediate amount before use. The offset is added to or subtracted from the base. A pre/post select decides whether the access uses the combined value or the untouched base.

The memory port, load data extension and the register file sit outside. A decode stage presents one request per cycle with `valid_i`. One cycle later the block returns the following:

- the effective address;
- the writeback value and a writeback strobe for the base register;
- a flag that marks an access not aligned to its size.

All address arithmetic wraps modulo 2^32.

Top module: `lsag_top`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first accepted request, `valid_o`, `addr_o`, `wb_val_o`, `wb_en_o` and `misalign_o` are all zero.
- R2: A request sampled with `valid_i` high at a rising clock edge produces its results with `valid_o` high after that edge. A cycle with `valid_i` low produces `valid_o`, `wb_en_o` and `misalign_o` low after the next edge.
- R3: With `use_reg_i` low, the offset is `imm_i` zero-extended from 12 bits to 32 bits.
- R4: With `use_reg_i` high, the offset is `offs_reg_i` shifted by `shift_amt_i` (0 to 31) positions. `shift_type_i` selects the kind of shift: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An amount of 0 leaves the register unchanged for every type.
- R5: With `sub_i` low, the combined value is base plus offset. With `sub_i` high, it is base minus offset. Both wrap modulo 2^32.
- R6: With `pre_i` high, `addr_o` equals the combined value. `wb_val_o` also equals the combined value.
- R7: With `pre_i` low (post-index), `addr_o` equals the unmodified base. `wb_val_o` equals the combined value, and `wb_en_o` is high.
- R8: With `pre_i` high, `wb_en_o` follows `wb_req_i`: pre-index writes back only when the request asks for it.
- R9: `misalign_o` is computed on `addr_o` using `size_i`: 0 = byte, 1 = half-word, 2 or 3 = word. The flag is high when a word access has a nonzero `addr_o[1:0]` or a half-word access has `addr_o[0]` set. A byte access never raises it.
- R10: Worked case with base 0x00009000 and immediate 4. Pre-index with writeback gives address 0x00009004, writeback value 0x00009004 and the strobe high. Pre-index without writeback gives address 0x00009004 with the strobe low. Post-index gives address 0x00009000, writeback value 0x00009004 and the strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned immediate offset |
| offs_reg_i | input | 32 | Offset register value |
| use_reg_i | input | 1 | 1 selects the register offset, 0 selects the immediate |
| shift_type_i | input | 2 | Register offset shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| shift_amt_i | input | 5 | Register offset shift amount |
| sub_i | input | 1 | 1 subtracts the offset from the base |
| pre_i | input | 1 | 1 pre-index, 0 post-index |
| wb_req_i | input | 1 | Writeback requested for pre-index |
| size_i | input | 2 | Access size (0 byte, 1 half, 2/3 word) |
| valid_o | output | 1 | Results valid |
| addr_o | output | 32 | Effective access address |
| wb_val_o | output | 32 | New base register value |
| wb_en_o | output | 1 | Base register writeback strobe |
| misalign_o | output | 1 | Access not aligned to its size |

## Verification
Every result is due exactly one rising edge after its request is sampled. This holds for the address, writeback value, strobe and alignment flag alike, because a single output register stage follows the combinational path. The bench drives each request at a falling edge and computes the expected tuple from its own model at that moment. It compares all outputs at the next falling edge, so every comparison falls one full edge after the stimulus it belongs to. Idle cycles are compared the same way, which confirms that the strobes drop one edge after `valid_i` falls.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned IMM_W  = 12;
  localparam int unsigned SAMT_W = $clog2(XLEN);

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;
endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter #(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     data_i,
  input  logic [1:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     data_o
);
  import lsag_pkg::*;

  logic [W-1:0] stage [AMT_W+1];

  assign stage[0] = data_i;

  // log2 barrel: stage k moves by 2^k when amt bit k is set
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      unique case (shift_e'(kind_i))
        SH_LSL:  moved = {stage[k][W-1-S:0], {S{1'b0}}};
        SH_LSR:  moved = {{S{1'b0}}, stage[k][W-1:S]};
        SH_ASR:  moved = {{S{stage[k][W-1]}}, stage[k][W-1:S]};
        default: moved = {stage[k][S-1:0], stage[k][W-1:S]};
      endcase
    end
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign data_o = stage[AMT_W];
endmodule

// File: rtl/lsag_offset.sv
module lsag_offset #(
  parameter int unsigned W     = 32,
  parameter int unsigned IW    = 12,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input  logic [IW-1:0]    imm_i,
  input  logic [W-1:0]     reg_i,
  input  logic             use_reg_i,
  input  logic [1:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     offs_o
);
  logic [W-1:0] reg_shifted;
  logic [W-1:0] imm_ext;

  lsag_shifter #(.W(W), .AMT_W(AMT_W)) u_shifter (
    .data_i (reg_i),
    .kind_i (kind_i),
    .amt_i  (amt_i),
    .data_o (reg_shifted)
  );

  assign imm_ext = {{(W-IW){1'b0}}, imm_i};
  assign offs_o  = use_reg_i ? reg_shifted : imm_ext;
endmodule

// File: rtl/lsag_align.sv
module lsag_align #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] addr_i,
  input  logic [1:0]   size_i,
  output logic         misalign_o
);
  import lsag_pkg::*;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = addr_i[0];
      default: misalign_o = |addr_i[1:0];
    endcase
  end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int unsigned W     = XLEN,
  parameter int unsigned IW    = IMM_W,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [W-1:0]     base_i,
  input  logic [IW-1:0]    imm_i,
  input  logic [W-1:0]     offs_reg_i,
  input  logic             use_reg_i,
  input  logic [1:0]       shift_type_i,
  input  logic [AMT_W-1:0] shift_amt_i,
  input  logic             sub_i,
  input  logic             pre_i,
  input  logic             wb_req_i,
  input  logic [1:0]       size_i,
  output logic             valid_o,
  output logic [W-1:0]     addr_o,
  output logic [W-1:0]     wb_val_o,
  output logic             wb_en_o,
  output logic             misalign_o
);
  logic [W-1:0] offs;
  logic [W-1:0] combined;
  logic [W-1:0] eff_addr;
  logic         mis_d;
  logic         wb_d;

  lsag_offset #(.W(W), .IW(IW), .AMT_W(AMT_W)) u_offset (
    .imm_i     (imm_i),
    .reg_i     (offs_reg_i),
    .use_reg_i (use_reg_i),
    .kind_i    (shift_type_i),
    .amt_i     (shift_amt_i),
    .offs_o    (offs)
  );

  // wraps at W bits
  assign combined = sub_i ? (base_i - offs) : (base_i + offs);
  assign eff_addr = pre_i ? combined : base_i;
  assign wb_d     = ~pre_i | wb_req_i;

  lsag_align #(.W(W)) u_align (
    .addr_i     (eff_addr),
    .size_i     (size_i),
    .misalign_o (mis_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      addr_o     <= '0;
      wb_val_o   <= '0;
      wb_en_o    <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      wb_en_o    <= valid_i & wb_d;
      misalign_o <= valid_i & mis_d;
      if (valid_i) begin
        addr_o   <= eff_addr;
        wb_val_o <= combined;
      end
    end
  end
endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned IW    = 12,
  parameter int unsigned AMT_W = $clog2(W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [W-1:0]     base_i,
  input logic [IW-1:0]    imm_i,
  input logic [W-1:0]     offs_reg_i,
  input logic             use_reg_i,
  input logic [1:0]       shift_type_i,
  input logic [AMT_W-1:0] shift_amt_i,
  input logic             sub_i,
  input logic             pre_i,
  input logic             wb_req_i,
  input logic [1:0]       size_i,
  input logic             valid_o,
  input logic [W-1:0]     addr_o,
  input logic [W-1:0]     wb_val_o,
  input logic             wb_en_o,
  input logic             misalign_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wb_en_o && !misalign_o));

  // R6
  pre_addr_eq_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pre_i) |=> (addr_o == wb_val_o));

  // R7
  post_base_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pre_i) |=> (wb_en_o && addr_o == $past(base_i)));

  // R8
  pre_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pre_i && !wb_req_i) |=> !wb_en_o);

  // R9
  byte_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd0) |=> !misalign_o);

  // R9
  word_mis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i[1]) |=> (misalign_o == (addr_o[1:0] != 2'b00)));
endmodule

bind lsag_top lsag_chk #(.W(W), .IW(IW), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/lsag_top_bench.sv
module lsag_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [11:0] imm_i = '0;
  logic [31:0] offs_reg_i = '0;
  logic        use_reg_i = 1'b0;
  logic [1:0]  shift_type_i = '0;
  logic [4:0]  shift_amt_i = '0;
  logic        sub_i = 1'b0;
  logic        pre_i = 1'b0;
  logic        wb_req_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic        valid_o;
  logic [31:0] addr_o;
  logic [31:0] wb_val_o;
  logic        wb_en_o;
  logic        misalign_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state: last accepted values hold when idle
  logic [31:0] m_addr = '0;
  logic [31:0] m_wb = '0;

  always #5 clk_i = ~clk_i;

  lsag_top u_lsag_top (.*);

  function automatic logic [31:0] ref_offs();
    longint unsigned x;
    int a;
    if (!use_reg_i) return {20'd0, imm_i};
    x = offs_reg_i;
    a = shift_amt_i;
    case (shift_type_i)
      2'd0: return 32'((x << a) & 64'hFFFF_FFFF);
      2'd1: return 32'(x >> a);
      2'd2: return 32'($signed(offs_reg_i) >>> a);
      default: return 32'(((x << 32) | x) >> a);
    endcase
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare one edge later at the next negedge
  task automatic step(string tag, bit v);
    logic [31:0] comb, ea;
    bit wb, mis;
    valid_i = v;
    comb = sub_i ? base_i - ref_offs() : base_i + ref_offs();
    ea = pre_i ? comb : base_i;
    wb = v && (!pre_i || wb_req_i);
    case (size_i)
      2'd0: mis = 0;
      2'd1: mis = ea[0];
      default: mis = ea[1:0] != 0;
    endcase
    mis = mis && v;
    if (v) begin m_addr = ea; m_wb = comb; end
    @(posedge clk_i);
    @(negedge clk_i);
    cmp({tag, " valid"}, {31'd0, valid_o}, {31'd0, v});
    cmp({tag, " addr"}, addr_o, m_addr);
    cmp({tag, " wbval"}, wb_val_o, m_wb);
    cmp({tag, " wben"}, {31'd0, wb_en_o}, {31'd0, wb});
    cmp({tag, " misalign"}, {31'd0, misalign_o}, {31'd0, mis});
  endtask

  task automatic set_imm(logic [31:0] b, logic [11:0] im, bit s, bit p, bit w, logic [1:0] sz);
    base_i = b; imm_i = im; use_reg_i = 0; sub_i = s; pre_i = p; wb_req_i = w; size_i = sz;
  endtask

  task automatic set_reg(logic [31:0] b, logic [31:0] r, logic [1:0] t, logic [4:0] a,
                         bit s, bit p, bit w, logic [1:0] sz);
    base_i = b; offs_reg_i = r; use_reg_i = 1; shift_type_i = t; shift_amt_i = a;
    sub_i = s; pre_i = p; wb_req_i = w; size_i = sz;
  endtask

  initial begin
    #1;
    // R1 reset values
    cmp("R1 valid", {31'd0, valid_o}, 32'd0);
    cmp("R1 addr", addr_o, 32'd0);
    cmp("R1 wbval", wb_val_o, 32'd0);
    cmp("R1 wben", {31'd0, wb_en_o}, 32'd0);
    cmp("R1 misalign", {31'd0, misalign_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R1 idle after reset", 0);

    // R10 worked cases
    set_imm(32'h9000, 12'd4, 0, 1, 1, 2'd2); step("R10 pre wb", 1);
    cmp("R10 pre wb addr", addr_o, 32'h9004);
    set_imm(32'h9000, 12'd4, 0, 1, 0, 2'd2); step("R10 pre nowb", 1);
    cmp("R10 pre nowb en", {31'd0, wb_en_o}, 32'd0);
    set_imm(32'h9000, 12'd4, 0, 0, 0, 2'd2); step("R10 post", 1);
    cmp("R10 post addr", addr_o, 32'h9000);
    cmp("R10 post wb", wb_val_o, 32'h9004);
    step("R2 idle", 0);

    // R3 full immediate zero-extended
    set_imm(32'h1000, 12'hFFF, 0, 1, 1, 2'd0); step("R3 imm max", 1);
    cmp("R3 imm max addr", addr_o, 32'h1FFF);
    // R5 subtract and wrap
    set_imm(32'h0, 12'd1, 1, 1, 1, 2'd0); step("R5 sub wrap", 1);
    cmp("R5 sub wrap addr", addr_o, 32'hFFFF_FFFF);
    set_imm(32'hFFFF_FFFC, 12'd8, 0, 1, 0, 2'd2); step("R5 add wrap", 1);
    cmp("R5 add wrap addr", addr_o, 32'h4);

    // R4 shifts
    set_reg(32'h1000, 32'd3, 2'd0, 5'd2, 0, 1, 1, 2'd2); step("R4 lsl2", 1);
    cmp("R4 lsl2 addr", addr_o, 32'h100C);
    set_reg(32'h0, 32'h8000_0000, 2'd1, 5'd4, 0, 1, 0, 2'd0); step("R4 lsr", 1);
    set_reg(32'h0, 32'h8000_0000, 2'd2, 5'd4, 0, 1, 0, 2'd0); step("R4 asr", 1);
    cmp("R4 asr addr", addr_o, 32'hF800_0000);
    set_reg(32'h0, 32'h0000_00F1, 2'd3, 5'd4, 0, 1, 0, 2'd0); step("R4 ror", 1);
    cmp("R4 ror addr", addr_o, 32'h1000_000F);
    set_reg(32'h10, 32'h8000_0001, 2'd2, 5'd0, 0, 1, 0, 2'd0); step("R4 amt0", 1);
    set_reg(32'h2000, 32'h0000_0010, 2'd0, 5'd31, 0, 0, 0, 2'd0); step("R4 lsl31 post", 1);
    // R5 register subtract, R7 post-index
    set_reg(32'h2000, 32'h10, 2'd0, 5'd0, 1, 0, 0, 2'd2); step("R7 post sub", 1);
    cmp("R7 post sub wb", wb_val_o, 32'h1FF0);

    // R9 alignment
    set_imm(32'h9000, 12'd2, 0, 1, 0, 2'd2); step("R9 word off2", 1);
    set_imm(32'h9000, 12'd2, 0, 1, 0, 2'd1); step("R9 half off2", 1);
    set_imm(32'h9000, 12'd1, 0, 1, 0, 2'd1); step("R9 half off1", 1);
    set_imm(32'h9000, 12'd3, 0, 1, 0, 2'd0); step("R9 byte off3", 1);
    set_imm(32'h9001, 12'd3, 0, 0, 0, 2'd3); step("R9 word alt post", 1);
    step("R2 idle end", 0);

    // R8 sweep of pre/wb combos with varied sizes
    for (int i = 0; i < 16; i++) begin
      set_imm(32'h4000 + i * 7, 12'(i * 13), i[0], i[1], i[2], 2'(i));
      step("R8 sweep", 1);
    end
    step("R2 idle final", 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule